// File: doc/BRIEF.md
# Transmit Path Reset Sequencer

This block brings the transmit side of a serial transceiver out of reset in a fixed order. The physical-medium side is handled first: a clock-calibration sub-reset, then a top-level physical-medium-attachment (PMA) sub-reset. The coding side follows: a forward-error-correction (FEC) sub-reset, then a top-level physical-coding-sublayer (PCS) sub-reset. Each stage raises its own strobe for a fixed number of clock cycles. Mask bits can leave any stage out, and a skipped stage takes no time. The two sides are always reset one after the other and never at the same time.

A full request holds the sequencer in a waiting state. When the request is released, the whole sequence runs. A PMA-only request starts the sequence at the PMA stage and then runs it to the end. Before it enters the coding-side stages, the sequencer stops and waits for the application to signal that its clocks are stable. When the last enabled stage has finished, a done flag goes high. The request inputs and the ready input are asynchronous. Each passes through a two-flop synchronizer, and the masks are assumed to be quasi-static.

Top module: `tx_rst_seq`

## Requirements
- R1: While rst_n is sampled low, every strobe and rst_done are low.
- R2: While the synchronized full request is high, no strobe is high. When full_rst_req falls, the first stage strobe rises on the third rising clock edge after the fall.
- R3: Every enabled stage holds its strobe high for exactly STAGE_CYCLES consecutive cycles. The default is 8.
- R4: At most one strobe is high at any time. Stages run in the order clock calibration, PMA, FEC, PCS.
- R5: pma_mask[0] enables clock calibration and pma_mask[1] enables the PMA stage. pcs_mask[0] enables FEC and pcs_mask[1] enables the PCS stage. A 0 bit skips the stage in zero cycles.
- R6: No FEC or PCS strobe and no rst_done appears until user_rdy has been seen high through its synchronizer. The sequencer waits without limit. After user_rdy rises, the first coding-side stage begins on the third rising edge.
- R7: A rising edge on pma_rst_req enters the sequence at the PMA stage on the third rising edge after it. The clock-calibration stage is left out, and rst_done is cleared at that edge.
- R8: rst_done stays low while a sequence runs. It rises one cycle after the last enabled stage ends, and it stays high until a new request arrives.
- R9: A full request during a sequence stops it. From the third rising edge, all strobes and rst_done are low. The sequence restarts from clock calibration when the request is released.
- R10: With every mask bit 0, rst_done rises on the cycle after user_rdy is seen synchronized high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| full_rst_req | input | 1 | Asynchronous full reset request; the sequence starts when it is released |
| pma_rst_req | input | 1 | Asynchronous PMA-only request; acts on its rising edge |
| user_rdy | input | 1 | Asynchronous indication that the application clocks are stable |
| pma_mask | input | 2 | Enables for the physical-medium stages: bit 0 calibration, bit 1 PMA |
| pcs_mask | input | 2 | Enables for the coding stages: bit 0 FEC, bit 1 PCS |
| ckcal_rst | output | 1 | Clock-calibration sub-reset strobe |
| pma_rst | output | 1 | PMA top sub-reset strobe |
| fec_rst | output | 1 | FEC sub-reset strobe |
| pcs_rst | output | 1 | PCS top sub-reset strobe |
| rst_done | output | 1 | Sequence complete |

## Verification
Every asynchronous input passes through two synchronizer flops, and the state register adds a third edge. A change on full_rst_req, pma_rst_req or user_rdy therefore first shows at the outputs after the third rising edge. Strobe lengths are counted directly in cycles. The done edge of each sequence is due 4 + 8 × (number of enabled stages) edges after release. In the ready-stall case it is due 3 + 8 × (enabled coding stages) edges after user_rdy rises. The bench drives inputs on falling edges and samples outputs on falling edges. It counts rising edges from the driving event, so each expected index is an exact edge count and not a window.

// File: rtl/tx_rst_pkg.sv
// Shared types for the transmit reset sequencer.
// Assumes: the stage order in seq_state_e is the order the sequencer visits stages.
package tx_rst_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_REL  = 3'd0,
        ST_CKCAL     = 3'd1,
        ST_PMA       = 3'd2,
        ST_WAIT_URDY = 3'd3,
        ST_FEC       = 3'd4,
        ST_PCS       = 3'd5,
        ST_DONE      = 3'd6
    } seq_state_e;

endpackage

// File: rtl/tx_rst_sync.sv
// Two-flop synchronizer bank for asynchronous control inputs.
// Assumes: each bit is an independent level; RST_VAL gives the value seen during reset.
module tx_rst_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two flops per bit; bits are independent, so one generate copy per bit.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[b] <= RST_VAL[b];
                sync_q[b] <= RST_VAL[b];
            end else begin
                meta_q[b] <= d_async[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/tx_rst_timer.sv
// Stage dwell timer: flags the last cycle of a STAGE_CYCLES-long stage.
// Assumes: clr is high on every cycle that is not inside a timed stage and
// on the last cycle before a stage change, so counting restarts at 0.
module tx_rst_timer #(
    parameter int STAGE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic last
);

    localparam int CNT_W = (STAGE_CYCLES > 1) ? $clog2(STAGE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAGE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles spent in the current stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CNT_LAST);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST); // R3

    AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/tx_rst_seq.sv
// Transmit reset sequencer top: steps calibration, PMA, FEC and PCS sub-resets
// in order, with per-stage masks, a user-ready hold before the coding stages,
// and a PMA-only entry point.
// Assumes: masks are quasi-static; requests and user_rdy are asynchronous.
module tx_rst_seq #(
    parameter int STAGE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       full_rst_req,
    input  logic       pma_rst_req,
    input  logic       user_rdy,
    input  logic [1:0] pma_mask,
    input  logic [1:0] pcs_mask,
    output logic       ckcal_rst,
    output logic       pma_rst,
    output logic       fec_rst,
    output logic       pcs_rst,
    output logic       rst_done
);

    import tx_rst_pkg::*;

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] sync_out;
    logic             full_s;
    logic             pma_s;
    logic             urdy_s;
    logic             pma_d;
    logic             pma_edge;
    logic             stage_last;
    logic             timed;
    logic             timer_clr;
    seq_state_e       state_q;
    seq_state_e       state_d;
    seq_state_e       pma_entry;
    seq_state_e       rel_entry;
    seq_state_e       pcs_entry;

    // Full request reads as asserted during reset so no stage starts early.
    tx_rst_sync #(.W(NSYNC), .RST_VAL(3'b001)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({user_rdy, pma_rst_req, full_rst_req}),
        .q_sync  (sync_out)
    );

    assign full_s = sync_out[0];
    assign pma_s  = sync_out[1];
    assign urdy_s = sync_out[2];

    // Delay the PMA-only request one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pma_d <= 1'b0;
        else        pma_d <= pma_s;
    end

    assign pma_edge = pma_s & ~pma_d;

    // First enabled stage from each entry point; a masked stage is passed over.
    always_comb begin
        pma_entry = pma_mask[1] ? ST_PMA : ST_WAIT_URDY;
        rel_entry = pma_mask[0] ? ST_CKCAL : pma_entry;
        if (pcs_mask[0])      pcs_entry = ST_FEC;
        else if (pcs_mask[1]) pcs_entry = ST_PCS;
        else                  pcs_entry = ST_DONE;
    end

    // Next-state decision: full request first, then PMA-only edge, then stepping.
    always_comb begin
        state_d = state_q;
        if (full_s) begin
            state_d = ST_WAIT_REL;
        end else if (pma_edge && state_q != ST_WAIT_REL) begin
            state_d = pma_entry;
        end else begin
            case (state_q)
                ST_WAIT_REL:  state_d = rel_entry;
                ST_CKCAL:     if (stage_last) state_d = pma_entry;
                ST_PMA:       if (stage_last) state_d = ST_WAIT_URDY;
                ST_WAIT_URDY: if (urdy_s)     state_d = pcs_entry;
                ST_FEC:       if (stage_last) state_d = pcs_mask[1] ? ST_PCS : ST_DONE;
                ST_PCS:       if (stage_last) state_d = ST_DONE;
                default:      state_d = state_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_REL;
        else        state_q <= state_d;
    end

    // Restart the dwell count on any stage change or outside timed stages.
    assign timed = (state_q == ST_CKCAL) || (state_q == ST_PMA) ||
                   (state_q == ST_FEC)   || (state_q == ST_PCS);
    assign timer_clr = !timed || (state_d != state_q);

    tx_rst_timer #(.STAGE_CYCLES(STAGE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .last  (stage_last)
    );

    // Output decode straight from the state register.
    assign ckcal_rst = (state_q == ST_CKCAL);
    assign pma_rst   = (state_q == ST_PMA);
    assign fec_rst   = (state_q == ST_FEC);
    assign pcs_rst   = (state_q == ST_PCS);
    assign rst_done  = (state_q == ST_DONE);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ckcal_rst, pma_rst, fec_rst, pcs_rst})); // R4

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |-> !(ckcal_rst || pma_rst || fec_rst || pcs_rst)); // R8

    AST_FEC_NEEDS_URDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fec_rst) |-> $past(urdy_s)); // R6

    AST_PCS_NEEDS_URDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcs_rst) |-> ($past(urdy_s) || $past(fec_rst))); // R6

    AST_FULL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        full_s |=> !(ckcal_rst || pma_rst || fec_rst || pcs_rst || rst_done)); // R9

    AST_CKCAL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ckcal_rst) |-> $past(pma_mask[0])); // R5

    AST_PMA_ONLY_NO_CKCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pma_edge && !full_s) |=> !ckcal_rst); // R7

    AST_DONE_AFTER_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_done) |-> ($past(urdy_s) || $past(fec_rst) || $past(pcs_rst))); // R8

endmodule

// File: tb/tx_rst_seq_tb_top.sv
// Self-checking bench for tx_rst_seq: vector table of mask settings, then
// directed tests for reset, hold, ready stall, PMA-only entry, abort and all-masked.
module tx_rst_seq_tb_top;

    localparam int STAGE = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       full_rst_req;
    logic       pma_rst_req;
    logic       user_rdy;
    logic [1:0] pma_mask;
    logic [1:0] pcs_mask;
    logic       ckcal_rst, pma_rst, fec_rst, pcs_rst, rst_done;

    int n_checks = 0;
    int n_errors = 0;

    // Row layout: [15:14] pma_mask, [13:12] pcs_mask, [11:0] done edge after release.
    localparam logic [15:0] VEC [0:7] = '{
        16'hF024, 16'h0004, 16'hA014, 16'h5014,
        16'h6014, 16'h9014, 16'h701C, 16'h800C
    };

    always #4 clk = ~clk;

    tx_rst_seq #(.STAGE_CYCLES(STAGE)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .full_rst_req (full_rst_req),
        .pma_rst_req  (pma_rst_req),
        .user_rdy     (user_rdy),
        .pma_mask     (pma_mask),
        .pcs_mask     (pcs_mask),
        .ckcal_rst    (ckcal_rst),
        .pma_rst      (pma_rst),
        .fec_rst      (fec_rst),
        .pcs_rst      (pcs_rst),
        .rst_done     (rst_done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Observe outputs each falling edge; index i = rising edges since the call point.
    task automatic watch(input int guard, input int limit,
                         output int w_ck, output int w_pma, output int w_fec,
                         output int w_pcs, output int done_at, output int first_rise,
                         output int order_ok);
        logic [3:0] prev;
        logic [3:0] cur;
        int rank;
        w_ck = 0; w_pma = 0; w_fec = 0; w_pcs = 0;
        done_at = -1; first_rise = -1; order_ok = 1; rank = -1;
        prev = {pcs_rst, fec_rst, pma_rst, ckcal_rst};
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            cur = {pcs_rst, fec_rst, pma_rst, ckcal_rst};
            w_ck += int'(cur[0]); w_pma += int'(cur[1]);
            w_fec += int'(cur[2]); w_pcs += int'(cur[3]);
            for (int k = 0; k < 4; k++) begin
                if (cur[k] && !prev[k]) begin
                    if (first_rise < 0) first_rise = i;
                    if (k <= rank) order_ok = 0;
                    rank = k;
                end
            end
            if ($countones(cur) > 1) order_ok = 0;
            prev = cur;
            if (rst_done && i > guard) begin
                done_at = i;
                break;
            end
        end
    endtask

    task automatic start_full(input logic [1:0] pm, input logic [1:0] cm);
        @(negedge clk);
        pma_mask = pm;
        pcs_mask = cm;
        full_rst_req = 1'b1;
        repeat (4) @(negedge clk);
        full_rst_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int wc, wp, wf, ws, dat, fr, ok, busy;
        rst_n = 1'b0;
        full_rst_req = 1'b1;
        pma_rst_req = 1'b0;
        user_rdy = 1'b1;
        pma_mask = 2'b11;
        pcs_mask = 2'b11;

        // R1: outputs quiet under reset
        repeat (3) @(negedge clk);
        check("R1", "strobes+done in reset",
              int'({ckcal_rst, pma_rst, fec_rst, pcs_rst, rst_done}), 0);
        rst_n = 1'b1;

        // R2: full request held, nothing moves
        busy = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            busy += int'(ckcal_rst | pma_rst | fec_rst | pcs_rst | rst_done);
        end
        check("R2", "busy cycles while held", busy, 0);

        // Vector table walk
        for (int v = 0; v < 8; v++) begin
            logic [1:0] pm;
            logic [1:0] cm;
            pm = VEC[v][15:14];
            cm = VEC[v][13:12];
            start_full(pm, cm);
            watch(0, 200, wc, wp, wf, ws, dat, fr, ok);
            check("R8", $sformatf("row %0d done edge", v), dat, int'(VEC[v][11:0]));
            check("R5", $sformatf("row %0d ckcal width", v), wc, pm[0] ? STAGE : 0);
            check("R3", $sformatf("row %0d pma width", v), wp, pm[1] ? STAGE : 0);
            check("R5", $sformatf("row %0d fec width", v), wf, cm[0] ? STAGE : 0);
            check("R3", $sformatf("row %0d pcs width", v), ws, cm[1] ? STAGE : 0);
            check("R4", $sformatf("row %0d order", v), ok, 1);
            if (v == 0) check("R2", "first strobe edge after release", fr, 3);
        end

        // R6: stall before coding stages until ready
        user_rdy = 1'b0;
        start_full(2'b11, 2'b11);
        watch(0, 100, wc, wp, wf, ws, dat, fr, ok);
        check("R6", "done while not ready", dat, -1);
        check("R6", "fec width while not ready", wf, 0);
        check("R6", "pma width before stall", wp, STAGE);
        user_rdy = 1'b1;
        watch(0, 60, wc, wp, wf, ws, dat, fr, ok);
        check("R6", "first coding edge after ready", fr, 3);
        check("R6", "done edge after ready", dat, 3 + 2 * STAGE);
        check("R3", "fec width after ready", wf, STAGE);

        // R7: PMA-only entry from done
        @(negedge clk);
        check("R8", "done held before pma request", int'(rst_done), 1);
        pma_rst_req = 1'b1;
        watch(3, 60, wc, wp, wf, ws, dat, fr, ok);
        check("R7", "ckcal width on pma-only", wc, 0);
        check("R7", "first strobe edge on pma-only", fr, 3);
        check("R7", "pma width on pma-only", wp, STAGE);
        check("R7", "done edge on pma-only", dat, 4 + 3 * STAGE);
        pma_rst_req = 1'b0;

        // R9: abort during PMA stage
        start_full(2'b11, 2'b11);
        watch(0, 14, wc, wp, wf, ws, dat, fr, ok);
        check("R9", "pma active before abort", int'(pma_rst), 1);
        full_rst_req = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", "pma still active 2 edges after abort", int'(pma_rst), 1);
        @(negedge clk);
        check("R9", "outputs after abort",
              int'({ckcal_rst, pma_rst, fec_rst, pcs_rst, rst_done}), 0);
        repeat (3) @(negedge clk);
        full_rst_req = 1'b0;
        watch(0, 100, wc, wp, wf, ws, dat, fr, ok);
        check("R9", "restart ckcal width", wc, STAGE);
        check("R9", "restart done edge", dat, 4 + 4 * STAGE);

        // R10: all masks zero
        user_rdy = 1'b0;
        start_full(2'b00, 2'b00);
        watch(0, 40, wc, wp, wf, ws, dat, fr, ok);
        check("R10", "done while not ready", dat, -1);
        check("R10", "no strobes", wc + wp + wf + ws, 0);
        user_rdy = 1'b1;
        watch(0, 20, wc, wp, wf, ws, dat, fr, ok);
        check("R10", "done edge after ready", dat, 3);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule